// File: doc/BRIEF.md
# Quadrature Encoder Counter with SPI Readout and Restore

This block turns the two phase signals and the index signal of one incremental encoder into three counters in the system clock domain. The first is a 32-bit two's-complement position that moves one count on every phase edge (x4 decoding). The second is a 16-bit count of index pulses. The third is a 16-bit count of phase steps that returns to zero on every index pulse. All phase, index and SPI inputs pass through a three-stage synchronizer, and edges are taken from its two oldest stages.

A host reads all three counters as one 64-bit frame on an SPI slave port in mode 3: the clock idles high, the slave changes data after a falling edge, and the host samples on the rising edge. The counters are frozen into the shift register when chip select falls. When the host raises the load-enable input, the same frame also carries saved counter values back into the block. The block applies them when chip select rises, so a position saved before power-down can be restored. An interrupt output goes high when an index pulse clears the step counter. It drops at the start of the next SPI frame.

The SPI port is a three-state machine. `SP_IDLE` waits for chip select to fall; on that edge it loads the snapshot and moves to `SP_XFER`. `SP_XFER` shifts on the SCK edges. When chip select rises it moves to `SP_COMMIT` if load-enable is high and at least 64 bits were clocked in; otherwise it returns to `SP_IDLE`. `SP_COMMIT` lasts one cycle, writes the received word into the counters and returns to `SP_IDLE`.

Top module: `qenc_spi_top`

## Requirements
- R1: The phase sequence (A,B) = 00→10→11→01→00 raises the position by one per transition, and the reverse sequence lowers it by one per transition.
- R2: A transition where A and B change together leaves all counters unchanged.
- R3: Each rising edge of the index input adds one to the 16-bit index counter.
- R4: Each valid phase step, in either direction, adds one to the 16-bit step counter. A rising index edge sets the step counter to 0, and a step that arrives in the same cycle as that edge is not added.
- R5: The interrupt goes high after an index edge clears the step counter. It goes low at the next falling edge of chip select. If both events occur in the same cycle, the interrupt stays high.
- R6: Each frame shifts out 64 bits, most significant bit first: position in bits 63..32, index counter in bits 31..16, step counter in bits 15..0. Each bit is driven on MISO after an SCK falling edge and is valid at the following rising edge.
- R7: The frame holds the counter values present when chip select fell. Phase steps during the frame do not change it.
- R8: With load-enable high, a frame of at least 64 SCK rising edges writes the last 64 MOSI bits into the counters when chip select rises. The bit layout is the same as in R6.
- R9: A frame with fewer than 64 rising edges leaves all counters unchanged, even with load-enable high.
- R10: With load-enable low, MOSI data has no effect on the counters.
- R11: A synchronous reset sets all counters, the interrupt, MISO and the shift register to 0.
- R12: The position wraps modulo 2^32: one step up from 0xFFFFFFFF gives 0, and one step down from 0 gives 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index pulse |
| load_en | input | 1 | Lets a full frame restore the counters |
| spi_sck | input | 1 | SPI clock, idles high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| irq | output | 1 | Step-counter-cleared interrupt |

## Verification
Two pairs of events can fall in the same clock cycle. The first pair is an index rising edge and a quadrature step. The bench drives the index and one phase in the same cycle and expects the step counter to read 0 while the position still moves. The second pair is an index edge that sets the interrupt and a chip-select fall that clears it. The bench raises the index together with chip select. It expects the frame to carry the values from before the clear and the interrupt to stay high until the frame after that one.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
    localparam int POS_W   = 32;
    localparam int IDX_W   = 16;
    localparam int PLS_W   = 16;
    localparam int FRAME_W = POS_W + IDX_W + PLS_W;
    localparam int SYNC_N  = 3;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_XFER,
        SP_COMMIT
    } spi_state_e;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int          W       = 6,
    parameter int          STAGES  = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    timeunit 1ns; timeprecision 1ps;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] sr;
        always_ff @(posedge clk) begin
            if (rst) sr <= {STAGES{RST_VAL[i]}};
            else     sr <= {sr[STAGES-2:0], din[i]};
        end
        assign cur[i]  = sr[STAGES-2];
        assign prev[i] = sr[STAGES-1];
    end
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder #(
    parameter int POS_W = qenc_pkg::POS_W,
    parameter int IDX_W = qenc_pkg::IDX_W,
    parameter int PLS_W = qenc_pkg::PLS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_cur,
    input  logic             a_prev,
    input  logic             b_cur,
    input  logic             b_prev,
    input  logic             idx_rise,
    input  logic             load,
    input  logic [POS_W-1:0] ld_pos,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [PLS_W-1:0] ld_pls,
    output logic [POS_W-1:0] pos,
    output logic [IDX_W-1:0] idx_cnt,
    output logic [PLS_W-1:0] pls_cnt,
    output logic             clr_evt
);
    timeunit 1ns; timeprecision 1ps;

    logic step, up;
    assign step    = a_cur ^ a_prev ^ b_cur ^ b_prev;
    assign up      = a_cur ^ b_prev;
    assign clr_evt = idx_rise && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            idx_cnt <= '0;
            pls_cnt <= '0;
        end else if (load) begin
            pos     <= ld_pos;
            idx_cnt <= ld_idx;
            pls_cnt <= ld_pls;
        end else begin
            if (step) pos <= up ? pos + POS_W'(1) : pos - POS_W'(1);
            if (idx_rise) begin
                idx_cnt <= idx_cnt + IDX_W'(1);
                pls_cnt <= '0;
            end else if (step) begin
                pls_cnt <= pls_cnt + PLS_W'(1);
            end
        end
    end

    // R1
    step_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (pos != $past(pos)));
    // R2
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(pos));
    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!idx_rise && !load) |=> $stable(idx_cnt));
    // R4
    pls_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (idx_rise && !load) |=> (pls_cnt == '0));
endmodule

// File: rtl/qenc_spi_port.sv
module qenc_spi_port #(
    parameter int FRAME_W = qenc_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sck_cur,
    input  logic               sck_prev,
    input  logic               cs_cur,
    input  logic               cs_prev,
    input  logic               mosi_cur,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] snap,
    output logic               miso,
    output logic               xfer_start,
    output logic               load_stb,
    output logic [FRAME_W-1:0] ld_word
);
    timeunit 1ns; timeprecision 1ps;
    import qenc_pkg::*;

    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    spi_state_e state, nstate;
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   bits;
    logic sck_rise, sck_fall, cs_fall, cs_rise;

    assign sck_rise = sck_cur & ~sck_prev;
    assign sck_fall = ~sck_cur & sck_prev;
    assign cs_fall  = ~cs_cur & cs_prev;
    assign cs_rise  = cs_cur & ~cs_prev;

    assign xfer_start = (state == SP_IDLE) && cs_fall;
    assign load_stb   = (state == SP_COMMIT);
    assign ld_word    = sh;

    always_ff @(posedge clk) begin
        if (rst) state <= SP_IDLE;
        else     state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            SP_IDLE:   if (cs_fall) nstate = SP_XFER;
            SP_XFER:   if (cs_rise) nstate = (load_en && bits == FULL) ? SP_COMMIT : SP_IDLE;
            SP_COMMIT: nstate = SP_IDLE;
            default:   nstate = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            bits <= '0;
            miso <= 1'b0;
        end else begin
            unique case (state)
                SP_IDLE: begin
                    if (cs_fall) begin
                        sh   <= snap;
                        bits <= '0;
                    end
                end
                SP_XFER: begin
                    if (sck_fall) begin
                        miso <= sh[FRAME_W-1];
                        sh   <= {sh[FRAME_W-2:0], 1'b0};
                    end else if (sck_rise) begin
                        sh[0] <= mosi_cur;
                        if (bits != FULL) bits <= bits + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R8
    commit_full_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> (bits == FULL));
    // R7
    snap_take_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> (sh == $past(snap)));
    // R10
    no_load_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SP_XFER && cs_rise && !load_en) |=> (state == SP_IDLE));
endmodule

// File: rtl/qenc_spi_top.sv
module qenc_spi_top #(
    parameter int POS_W  = qenc_pkg::POS_W,
    parameter int IDX_W  = qenc_pkg::IDX_W,
    parameter int PLS_W  = qenc_pkg::PLS_W,
    parameter int SYNC_N = qenc_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic enc_a,
    input  logic enc_b,
    input  logic enc_idx,
    input  logic load_en,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic irq
);
    timeunit 1ns; timeprecision 1ps;

    localparam int FRAME_W = POS_W + IDX_W + PLS_W;
    localparam int NSIG    = 6;
    // bit order: a, b, idx, sck, cs_n, mosi ; idle levels sck=1, cs_n=1
    localparam logic [NSIG-1:0] IDLE_LVL = 6'b000110;

    logic [NSIG-1:0] s_cur, s_prev;
    logic unused_mosi_prev;
    logic idx_rise, clr_evt, xfer_start, load_stb;
    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] idx_cnt;
    logic [PLS_W-1:0] pls_cnt;
    logic [FRAME_W-1:0] ld_word;

    qenc_sync #(.W(NSIG), .STAGES(SYNC_N), .RST_VAL(IDLE_LVL)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({enc_a, enc_b, enc_idx, spi_sck, spi_cs_n, spi_mosi}),
        .cur (s_cur),
        .prev(s_prev)
    );
    assign unused_mosi_prev = s_prev[0];
    assign idx_rise = s_cur[3] & ~s_prev[3];

    qenc_decoder #(.POS_W(POS_W), .IDX_W(IDX_W), .PLS_W(PLS_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .a_cur   (s_cur[5]),
        .a_prev  (s_prev[5]),
        .b_cur   (s_cur[4]),
        .b_prev  (s_prev[4]),
        .idx_rise(idx_rise),
        .load    (load_stb),
        .ld_pos  (ld_word[FRAME_W-1 -: POS_W]),
        .ld_idx  (ld_word[PLS_W +: IDX_W]),
        .ld_pls  (ld_word[0 +: PLS_W]),
        .pos     (pos),
        .idx_cnt (idx_cnt),
        .pls_cnt (pls_cnt),
        .clr_evt (clr_evt)
    );

    qenc_spi_port #(.FRAME_W(FRAME_W)) u_spi (
        .clk       (clk),
        .rst       (rst),
        .sck_cur   (s_cur[2]),
        .sck_prev  (s_prev[2]),
        .cs_cur    (s_cur[1]),
        .cs_prev   (s_prev[1]),
        .mosi_cur  (s_cur[0]),
        .load_en   (load_en),
        .snap      ({pos, idx_cnt, pls_cnt}),
        .miso      (spi_miso),
        .xfer_start(xfer_start),
        .load_stb  (load_stb),
        .ld_word   (ld_word)
    );

    always_ff @(posedge clk) begin
        if (rst)             irq <= 1'b0;
        else if (clr_evt)    irq <= 1'b1;
        else if (xfer_start) irq <= 1'b0;
    end

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        clr_evt |=> irq);
    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_start && !clr_evt) |=> !irq);
    // R11
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (!irq && !spi_miso));
endmodule

// File: tb/sim_qenc_spi_top.sv
module sim_qenc_spi_top;
    timeunit 1ns; timeprecision 1ps;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, load_en = 1'b0;
    logic sck = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic miso, irq;

    always #2.5 clk = ~clk;

    qenc_spi_top u0 (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .load_en(load_en), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .irq(irq)
    );

    typedef struct {
        logic [63:0] val;
        logic [63:0] mask;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    logic [63:0] rx_word;
    event frame_ev;
    logic [31:0] m_pos = '0;
    logic [15:0] m_idx = '0, m_pls = '0;
    int qs = 0;

    function automatic logic [63:0] model();
        return {m_pos, m_idx, m_pls};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_q();
        case (qs)
            0: {enc_a, enc_b} = 2'b00;
            1: {enc_a, enc_b} = 2'b10;
            2: {enc_a, enc_b} = 2'b11;
            default: {enc_a, enc_b} = 2'b01;
        endcase
    endtask

    task automatic step(input bit up);
        qs = (qs + (up ? 1 : 3)) % 4;
        drive_q();
        m_pos = up ? m_pos + 32'd1 : m_pos - 32'd1;
        m_pls = m_pls + 16'd1;
        cyc(HALF);
    endtask

    task automatic idx_pulse();
        enc_idx = 1'b1; cyc(HALF);
        enc_idx = 1'b0; cyc(HALF);
        m_idx = m_idx + 16'd1;
        m_pls = '0;
    endtask

    // driver: pushes the expected frame, then runs it on the SPI pins
    task automatic frame(input logic [63:0] tx, input int nbits, input string tag,
                         input bit mid_step, input bit idx_at_start);
        logic [63:0] mask;
        logic [63:0] got;
        got  = '0;
        mask = (nbits >= 64) ? '1 : ~(64'hFFFF_FFFF_FFFF_FFFF >> nbits);
        exp_q.push_back('{val: model(), mask: mask, tag: tag});
        cs_n = 1'b0;
        if (idx_at_start) enc_idx = 1'b1;
        cyc(HALF);
        if (idx_at_start) begin
            enc_idx = 1'b0;
            m_idx = m_idx + 16'd1;
            m_pls = '0;
        end
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0; mosi = tx[63-i];
            cyc(HALF);
            got[63-i] = miso;
            sck = 1'b1;
            cyc(HALF);
            if (mid_step && i == 20) step(1'b1);
        end
        cs_n = 1'b1;
        cyc(HALF + 4);
        rx_word = got;
        ->frame_ev;
        cyc(2);
    endtask

    // monitor: compares each finished frame with the head of the queue
    initial begin
        forever begin
            @(frame_ev);
            if (exp_q.size() == 0) begin
                chk("R6 unexpected frame", rx_word, '0);
                n_fail++;
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, rx_word & e.mask, e.val & e.mask);
            end
        end
    end

    initial begin
        cyc(150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(6);
        rst = 1'b0;
        cyc(4);
        chk("R11 irq after reset", 64'(irq), 64'd0);
        chk("R11 miso after reset", 64'(miso), 64'd0);
        frame(64'h0, 64, "R11 counters read zero", 1'b0, 1'b0);

        for (int i = 0; i < 5; i++) step(1'b1);
        frame(64'h0, 64, "R1 R6 forward five", 1'b0, 1'b0);

        for (int i = 0; i < 8; i++) step(1'b0);
        frame(64'h0, 64, "R1 reverse to -3", 1'b0, 1'b0);

        qs = (qs + 2) % 4; drive_q(); cyc(HALF);
        frame(64'h0, 64, "R2 double change ignored", 1'b0, 1'b0);
        step(1'b1);

        idx_pulse();
        chk("R5 irq set by index", 64'(irq), 64'd1);
        frame(64'h0, 64, "R3 R4 index counted, steps cleared", 1'b0, 1'b0);
        chk("R5 irq cleared by frame", 64'(irq), 64'd0);

        for (int i = 0; i < 3; i++) step(1'b1);
        qs = (qs + 1) % 4; drive_q(); enc_idx = 1'b1;
        m_pos = m_pos + 32'd1; m_idx = m_idx + 16'd1; m_pls = '0;
        cyc(HALF); enc_idx = 1'b0; cyc(HALF);
        frame(64'h0, 64, "R4 index with coinciding step", 1'b0, 1'b0);

        step(1'b0); step(1'b0);
        frame(64'h0, 64, "R5 snapshot at set/clear race", 1'b0, 1'b1);
        chk("R5 set wins over clear", 64'(irq), 64'd1);
        frame(64'h0, 64, "R3 index at frame start", 1'b0, 1'b0);
        chk("R5 irq cleared after race", 64'(irq), 64'd0);

        frame(64'h0, 64, "R7 frozen during steps", 1'b1, 1'b0);
        frame(64'h0, 64, "R7 step applied after", 1'b0, 1'b0);

        frame(64'hA5A5_5A5A_C3C3_3C3C, 64, "R10 write without enable", 1'b0, 1'b0);
        frame(64'h0, 64, "R10 counters unchanged", 1'b0, 1'b0);

        load_en = 1'b1;
        frame(64'h1234_5678_00AB_00CD, 64, "R8 read before load", 1'b0, 1'b0);
        load_en = 1'b0;
        {m_pos, m_idx, m_pls} = 64'h1234_5678_00AB_00CD;
        frame(64'h0, 64, "R8 restored values", 1'b0, 1'b0);

        load_en = 1'b1;
        frame(64'hFFFF_0000_FFFF_0000, 40, "R9 short frame read", 1'b0, 1'b0);
        load_en = 1'b0;
        frame(64'h0, 64, "R9 short frame no load", 1'b0, 1'b0);

        load_en = 1'b1;
        frame(64'hFFFF_FFFF_0007_FFFF, 64, "R8 load before wrap", 1'b0, 1'b0);
        load_en = 1'b0;
        {m_pos, m_idx, m_pls} = 64'hFFFF_FFFF_0007_FFFF;
        step(1'b1);
        frame(64'h0, 64, "R12 wrap up to zero", 1'b0, 1'b0);
        step(1'b0);
        frame(64'h0, 64, "R12 wrap down to all ones", 1'b0, 1'b0);

        cyc(20);
        chk("R6 all frames compared", 64'(exp_q.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule